// File: doc/BRIEF.md
# Interrupt Status Unit with Clear-on-Read

This block keeps the interrupt code, status and sequence-step registers of a small SCSI-style host adapter. It also keeps the three transfer-count bytes and the first configuration register. It drives one level-sensitive interrupt line. Single-cycle event pulses come in from the adapter's sequencing logic: selection timeout to an absent target, DMA done, function complete, bus service and bus reset. A byte-wide register port carries software reads and writes, and commands are written through it to a command address.

The status register's pending bit and the interrupt line are one and the same state. Every event that raises the line sets that bit. Reading the interrupt-code register returns the code it held, and the same read clears the code, clears terminal count, drops the line and leaves the sequence step at the command-done value. An event that arrives in the same cycle as that read still takes effect, so no interrupt is lost.

Top module: `isu_status_unit`

## Requirements
- R1: After reset, and after no other stimulus, the registers read as follows: address 0 and address 1 (transfer count low and middle) read 0x00, address 2 (transfer count high) reads CHIP_ID (default 0xA2), address 4 (status) reads 0x00, address 5 (interrupt code) reads 0x00, address 6 (sequence step, low three bits) reads 0x00, address 8 (configuration 1) reads 0x07, and irq is low.
- R2: Status bit 7 is the interrupt-pending bit and always equals irq. rdata shows the addressed register in the cycle rd_en is high and reads 0x00 otherwise.
- R3: A read of address 5 returns the code held before the read. On the next cycle the code is 0x00, status bit 4 (terminal count) is 0, the sequence step is 4 (command done) and irq is low, unless an event or command of R4 to R13 acts in that same cycle.
- R4: A write of 0x03 to address 3 (the command address; bit 7 of any command is ignored), or a pulse on ev_bus_reset, loads 0x80 into the interrupt code. It raises irq only when bit 6 (reset-report disable) of configuration 1 is 0, judged on the value held before that cycle.
- R5: An ev_sel_timeout pulse clears status bit 4, loads 0x20 (disconnect), sets the sequence step to 0 and raises irq, so status reads 0x80.
- R6: An ev_dma_done pulse sets status bit 4, loads 0x10 (bus service), sets the sequence step to 0, zeroes all three transfer-count bytes and raises irq.
- R7: Command 0x01 (flush) loads 0x08 (function complete) and sets the sequence step to 0. It leaves irq as it was.
- R8: Command 0x12 (message accept) loads 0x20, sets the sequence step to 0 and raises irq. Command 0x45 (disable selection) loads 0x00 and raises irq.
- R9: A write to address 0, 1 or 2 stores the byte in that transfer-count register and clears status bit 4.
- R10: Event pulses win over an interrupt-code read and over register writes in the same cycle. When several events pulse together, only the first in the order selection timeout, DMA done, function complete, bus service, bus reset takes effect.
- R11: Writes to addresses 4, 5 and 6 change nothing.
- R12: Command 0x02 (soft reset) returns every register to its R1 value and drops irq. It overrides any event pulsed in the same cycle.
- R13: An ev_func_cmplt pulse loads 0x18 (bus service with function complete), sets the sequence step to 4 and raises irq. An ev_bus_svc pulse ORs 0x10 into the code held before that cycle and raises irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| rd_en | input | 1 | Register read strobe, one cycle per access |
| wr_en | input | 1 | Register write strobe, never high together with rd_en |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| ev_sel_timeout | input | 1 | Selection to an absent target timed out |
| ev_dma_done | input | 1 | DMA transfer finished |
| ev_func_cmplt | input | 1 | Selection and command phase finished |
| ev_bus_svc | input | 1 | Target requests bus service |
| ev_bus_reset | input | 1 | Bus reset was seen |
| irq | output | 1 | Level interrupt to the host |

## Verification
The hardest case to reach from the ports is a collision in a single clock: a clear-on-read of the interrupt code landing in the same cycle as an event pulse, or several events pulsing together, or a soft reset meeting an event. The directed part of the stimulus lines these up on the same cycle on purpose. A reset-report-disabled bus reset is also run against both an idle line and a pending one. A long pseudo-random stream then mixes reads, writes, commands and sparse bursts of coincident events, so collisions turn up in many register states.

// File: rtl/isu_pkg.sv
package isu_pkg;
   // register addresses
   localparam int unsigned A_TC_LO  = 0;
   localparam int unsigned A_TC_MID = 1;
   localparam int unsigned A_TC_HI  = 2;
   localparam int unsigned A_CMD    = 3;
   localparam int unsigned A_STAT   = 4;
   localparam int unsigned A_INTR   = 5;
   localparam int unsigned A_SEQ    = 6;
   localparam int unsigned A_CFG1   = 8;

   // command opcodes (bit 7 of the written byte is ignored)
   localparam logic [6:0] C_FLUSH  = 7'h01;
   localparam logic [6:0] C_SRST   = 7'h02;
   localparam logic [6:0] C_BRST   = 7'h03;
   localparam logic [6:0] C_MSGACC = 7'h12;
   localparam logic [6:0] C_DISSEL = 7'h45;

   // interrupt codes
   localparam logic [7:0] I_RST  = 8'h80;
   localparam logic [7:0] I_DISC = 8'h20;
   localparam logic [7:0] I_BSVC = 8'h10;
   localparam logic [7:0] I_FC   = 8'h08;

   localparam logic [2:0] SEQ_DONE     = 3'd4;
   localparam int         CFG1_RRD_BIT = 6;

   // event indices, lowest index has highest precedence
   localparam int NEV      = 5;
   localparam int EV_SELTO = 0;
   localparam int EV_DMA   = 1;
   localparam int EV_FC    = 2;
   localparam int EV_BSVC  = 3;
   localparam int EV_BRST  = 4;

   typedef struct packed {
      logic       pend;
      logic       tc;
      logic [7:0] intr;
      logic [2:0] seq;
      logic [7:0] tc_lo;
      logic [7:0] tc_mid;
      logic [7:0] tc_hi;
      logic [7:0] cfg1;
   } isu_state_t;

   typedef struct packed {
      logic       flush;
      logic       srst;
      logic       brst;
      logic       msgacc;
      logic       dissel;
      logic       cfg1;
      logic [2:0] tc;
   } isu_wr_t;
endpackage

// File: rtl/isu_cmd_decode.sv
module isu_cmd_decode
   import isu_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [6:0]        op,
   output isu_wr_t           dec
);
   logic cmd_hit;

   always_comb begin
      cmd_hit    = wr_en && (addr == ADDR_W'(A_CMD));
      dec        = '0;
      dec.flush  = cmd_hit && (op == C_FLUSH);
      dec.srst   = cmd_hit && (op == C_SRST);
      dec.brst   = cmd_hit && (op == C_BRST);
      dec.msgacc = cmd_hit && (op == C_MSGACC);
      dec.dissel = cmd_hit && (op == C_DISSEL);
      dec.cfg1   = wr_en && (addr == ADDR_W'(A_CFG1));
      for (int b = 0; b < 3; b++)
         dec.tc[b] = wr_en && (addr == ADDR_W'(A_TC_LO + b));
   end
endmodule

// File: rtl/isu_event_pick.sv
module isu_event_pick #(
   parameter int N = 5
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);
   logic [N-1:0] seen;

   if (N < 1) begin : g_bad_n
      $error("isu_event_pick: N must be at least 1");
   end

   assign seen[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_slot
      assign grant[i] = req[i] & ~seen[i];
      if (i < N - 1) begin : g_chain
         assign seen[i+1] = seen[i] | req[i];
      end
   end
endmodule

// File: rtl/isu_next.sv
module isu_next
   import isu_pkg::*;
(
   input  isu_state_t     cur,
   input  isu_state_t     rst_val,
   input  logic           rd_clr,
   input  isu_wr_t        wr,
   input  logic [7:0]     wdata,
   input  logic [NEV-1:0] grant,
   output isu_state_t     nxt
);
   logic report_ok;

   always_comb begin
      report_ok = ~cur.cfg1[CFG1_RRD_BIT];
      nxt = cur;
      // lowest precedence: clear-on-read side effect
      if (rd_clr) begin
         nxt.intr = '0;
         nxt.tc   = 1'b0;
         nxt.seq  = SEQ_DONE;
         nxt.pend = 1'b0;
      end
      // register writes and commands
      if (wr.tc[0]) begin nxt.tc_lo  = wdata; nxt.tc = 1'b0; end
      if (wr.tc[1]) begin nxt.tc_mid = wdata; nxt.tc = 1'b0; end
      if (wr.tc[2]) begin nxt.tc_hi  = wdata; nxt.tc = 1'b0; end
      if (wr.cfg1) nxt.cfg1 = wdata;
      if (wr.flush) begin
         nxt.intr = I_FC;
         nxt.seq  = '0;
      end
      if (wr.brst) begin
         nxt.intr = I_RST;
         if (report_ok) nxt.pend = 1'b1;
      end
      if (wr.msgacc) begin
         nxt.intr = I_DISC;
         nxt.seq  = '0;
         nxt.pend = 1'b1;
      end
      if (wr.dissel) begin
         nxt.intr = '0;
         nxt.pend = 1'b1;
      end
      // events override reads and writes; grant is one-hot
      if (grant[EV_SELTO]) begin
         nxt.tc   = 1'b0;
         nxt.intr = I_DISC;
         nxt.seq  = '0;
         nxt.pend = 1'b1;
      end
      if (grant[EV_DMA]) begin
         nxt.tc     = 1'b1;
         nxt.intr   = I_BSVC;
         nxt.seq    = '0;
         nxt.tc_lo  = '0;
         nxt.tc_mid = '0;
         nxt.tc_hi  = '0;
         nxt.pend   = 1'b1;
      end
      if (grant[EV_FC]) begin
         nxt.intr = I_BSVC | I_FC;
         nxt.seq  = SEQ_DONE;
         nxt.pend = 1'b1;
      end
      if (grant[EV_BSVC]) begin
         nxt.intr = cur.intr | I_BSVC;
         nxt.pend = 1'b1;
      end
      if (grant[EV_BRST]) begin
         nxt.intr = I_RST;
         if (report_ok) nxt.pend = 1'b1;
      end
      // soft reset beats everything
      if (wr.srst) nxt = rst_val;
   end
endmodule

// File: rtl/isu_status_unit.sv
module isu_status_unit
   import isu_pkg::*;
#(
   parameter int         ADDR_W    = 4,
   parameter logic [7:0] CHIP_ID   = 8'hA2,
   parameter logic [7:0] CFG1_INIT = 8'h07,
   parameter bit         RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   input  logic              ev_sel_timeout,
   input  logic              ev_dma_done,
   input  logic              ev_func_cmplt,
   input  logic              ev_bus_svc,
   input  logic              ev_bus_reset,
   output logic              irq
);
   localparam isu_state_t RST_VAL = '{
      pend: 1'b0, tc: 1'b0, intr: 8'h00, seq: 3'd0,
      tc_lo: 8'h00, tc_mid: 8'h00, tc_hi: CHIP_ID, cfg1: CFG1_INIT};

   if (ADDR_W < 4) begin : g_bad_addr
      $error("isu_status_unit: ADDR_W must be at least 4");
   end

   isu_state_t     st_q, st_d;
   isu_wr_t        wr_dec;
   logic [NEV-1:0] ev_vec, ev_gnt;
   logic           rd_clr;
   logic [7:0]     rd_mux;

   assign ev_vec[EV_SELTO] = ev_sel_timeout;
   assign ev_vec[EV_DMA]   = ev_dma_done;
   assign ev_vec[EV_FC]    = ev_func_cmplt;
   assign ev_vec[EV_BSVC]  = ev_bus_svc;
   assign ev_vec[EV_BRST]  = ev_bus_reset;
   assign rd_clr = rd_en && (addr == ADDR_W'(A_INTR));

   isu_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
      .wr_en (wr_en),
      .addr  (addr),
      .op    (wdata[6:0]),
      .dec   (wr_dec)
   );

   isu_event_pick #(.N(NEV)) u_pick (
      .req   (ev_vec),
      .grant (ev_gnt)
   );

   isu_next u_next (
      .cur     (st_q),
      .rst_val (RST_VAL),
      .rd_clr  (rd_clr),
      .wr      (wr_dec),
      .wdata   (wdata),
      .grant   (ev_gnt),
      .nxt     (st_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= RST_VAL;
      else        st_q <= st_d;
   end

   assign irq = st_q.pend;

   always_comb begin
      case (addr)
         ADDR_W'(A_TC_LO):  rd_mux = st_q.tc_lo;
         ADDR_W'(A_TC_MID): rd_mux = st_q.tc_mid;
         ADDR_W'(A_TC_HI):  rd_mux = st_q.tc_hi;
         ADDR_W'(A_STAT):   rd_mux = {st_q.pend, 2'b00, st_q.tc, 4'b0000};
         ADDR_W'(A_INTR):   rd_mux = st_q.intr;
         ADDR_W'(A_SEQ):    rd_mux = {5'b00000, st_q.seq};
         ADDR_W'(A_CFG1):   rd_mux = st_q.cfg1;
         default:           rd_mux = 8'h00;
      endcase
   end

   if (RDATA_REG) begin : g_rd_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdata <= '0;
         else        rdata <= rd_en ? rd_mux : 8'h00;
      end
   end else begin : g_rd_comb
      assign rdata = rd_en ? rd_mux : 8'h00;
   end
endmodule

// File: rtl/isu_status_unit_chk.sv
module isu_status_unit_chk
   import isu_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter bit RDATA_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [7:0]        wdata,
   input logic [7:0]        rdata,
   input logic              ev_sel_timeout,
   input logic              ev_dma_done,
   input logic              ev_func_cmplt,
   input logic              ev_bus_svc,
   input logic              ev_bus_reset,
   input logic              irq,
   input logic              cfg1_rrd
);
   logic       cmd_wr, rd_int, srst, any_ev, raising_ev;
   logic [6:0] code;

   assign cmd_wr     = wr_en && (addr == ADDR_W'(A_CMD));
   assign code       = wdata[6:0];
   assign rd_int     = rd_en && (addr == ADDR_W'(A_INTR));
   assign srst       = cmd_wr && (code == C_SRST);
   assign raising_ev = ev_sel_timeout | ev_dma_done | ev_func_cmplt | ev_bus_svc;
   assign any_ev     = raising_ev | ev_bus_reset;

   always @(posedge clk) begin
      if (!rst_n) assert_reset_quiet_R1: assert (!irq);
   end

   if (RDATA_REG == 1'b0) begin : g_mirror
      assert_mirror_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && addr == ADDR_W'(A_STAT)) |-> (rdata[7] == irq));
   end

   assert_read_lowers_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_int && !any_ev && !wr_en) |=> !irq);

   assert_brst_report_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && code == C_BRST && !cfg1_rrd) |=> irq);

   assert_brst_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && code == C_BRST && cfg1_rrd && !irq && !any_ev) |=> !irq);

   assert_seltimeout_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_sel_timeout && !srst) |=> irq);

   assert_dma_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_dma_done && !srst) |=> irq);

   assert_flush_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && code == C_FLUSH && !any_ev) |=> $stable(irq));

   assert_msg_dissel_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && (code == C_MSGACC || code == C_DISSEL)) |=> irq);

   assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_int && raising_ev && !srst) |=> irq);

   assert_soft_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> !irq);

   assert_fc_bsvc_R13: assert property (@(posedge clk) disable iff (!rst_n)
      ((ev_func_cmplt || ev_bus_svc) && !srst) |=> irq);
endmodule

bind isu_status_unit isu_status_unit_chk #(
   .ADDR_W    (ADDR_W),
   .RDATA_REG (RDATA_REG)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .rd_en          (rd_en),
   .wr_en          (wr_en),
   .addr           (addr),
   .wdata          (wdata),
   .rdata          (rdata),
   .ev_sel_timeout (ev_sel_timeout),
   .ev_dma_done    (ev_dma_done),
   .ev_func_cmplt  (ev_func_cmplt),
   .ev_bus_svc     (ev_bus_svc),
   .ev_bus_reset   (ev_bus_reset),
   .irq            (irq),
   .cfg1_rrd       (st_q.cfg1[isu_pkg::CFG1_RRD_BIT])
);

// File: tb/tb_isu_status_unit.sv
`timescale 1ns/1ps
module tb_isu_status_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rd_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [4:0] evv = '0;   // [0] seltimeout [1] dma [2] fc [3] bsvc [4] busreset
   logic [7:0] rdata;
   logic       irq;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   // reference model state
   logic       m_pend, m_tc;
   logic [7:0] m_intr, m_lo, m_mid, m_hi, m_cfg1;
   logic [2:0] m_seq;

   always #2 clk = ~clk;

   isu_status_unit dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .rd_en          (rd_en),
      .wr_en          (wr_en),
      .addr           (addr),
      .wdata          (wdata),
      .rdata          (rdata),
      .ev_sel_timeout (evv[0]),
      .ev_dma_done    (evv[1]),
      .ev_func_cmplt  (evv[2]),
      .ev_bus_svc     (evv[3]),
      .ev_bus_reset   (evv[4]),
      .irq            (irq)
   );

   task automatic mreset();
      m_pend = 1'b0; m_tc = 1'b0; m_intr = 8'h00; m_seq = 3'd0;
      m_lo = 8'h00; m_mid = 8'h00; m_hi = 8'hA2; m_cfg1 = 8'h07;
   endtask

   function automatic logic [7:0] mread(input logic [3:0] a);
      case (a)
         4'd0: return m_lo;
         4'd1: return m_mid;
         4'd2: return m_hi;
         4'd4: return {m_pend, 2'b00, m_tc, 4'b0000};
         4'd5: return m_intr;
         4'd6: return {5'b00000, m_seq};
         4'd8: return m_cfg1;
         default: return 8'h00;
      endcase
   endfunction

   task automatic mclock(input bit rd, input bit wr, input logic [3:0] a,
                         input logic [7:0] d, input logic [4:0] ev);
      logic [7:0] o_intr;
      logic       quiet_rst;
      o_intr    = m_intr;
      quiet_rst = m_cfg1[6];
      if (wr && a == 4'd3 && d[6:0] == 7'h02) begin
         mreset();
         return;
      end
      if (rd && a == 4'd5) begin
         m_intr = 8'h00; m_tc = 1'b0; m_seq = 3'd4; m_pend = 1'b0;
      end
      if (wr) begin
         if (a == 4'd0) begin m_lo = d; m_tc = 1'b0; end
         if (a == 4'd1) begin m_mid = d; m_tc = 1'b0; end
         if (a == 4'd2) begin m_hi = d; m_tc = 1'b0; end
         if (a == 4'd8) m_cfg1 = d;
         if (a == 4'd3) begin
            case (d[6:0])
               7'h01: begin m_intr = 8'h08; m_seq = 3'd0; end
               7'h03: begin m_intr = 8'h80; if (!quiet_rst) m_pend = 1'b1; end
               7'h12: begin m_intr = 8'h20; m_seq = 3'd0; m_pend = 1'b1; end
               7'h45: begin m_intr = 8'h00; m_pend = 1'b1; end
               default: ;
            endcase
         end
      end
      if (ev[0]) begin
         m_tc = 1'b0; m_intr = 8'h20; m_seq = 3'd0; m_pend = 1'b1;
      end else if (ev[1]) begin
         m_tc = 1'b1; m_intr = 8'h10; m_seq = 3'd0; m_pend = 1'b1;
         m_lo = 8'h00; m_mid = 8'h00; m_hi = 8'h00;
      end else if (ev[2]) begin
         m_intr = 8'h18; m_seq = 3'd4; m_pend = 1'b1;
      end else if (ev[3]) begin
         m_intr = o_intr | 8'h10; m_pend = 1'b1;
      end else if (ev[4]) begin
         m_intr = 8'h80; if (!quiet_rst) m_pend = 1'b1;
      end
   endtask

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic step(input bit rd, input bit wr, input logic [3:0] a,
                       input logic [7:0] d, input logic [4:0] ev, input string tag);
      @(negedge clk);
      rd_en = rd; wr_en = wr; addr = a; wdata = d; evv = ev;
      #1;
      check({tag, " irq (R2)"}, {7'd0, irq}, {7'd0, m_pend});
      if (rd) check({tag, " rdata"}, rdata, mread(a));
      @(posedge clk);
      mclock(rd, wr, a, d, ev);
   endtask

   task automatic rreg(input logic [3:0] a, input string tag);
      step(1'b1, 1'b0, a, 8'h00, 5'b0, tag);
   endtask
   task automatic wreg(input logic [3:0] a, input logic [7:0] d, input string tag);
      step(1'b0, 1'b1, a, d, 5'b0, tag);
   endtask
   task automatic pulse(input logic [4:0] ev, input string tag);
      step(1'b0, 1'b0, 4'd0, 8'h00, ev, tag);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog (all requirements): actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      logic [3:0]  a;
      logic [7:0]  cmd, wd;
      logic [4:0]  ev;
      mreset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 irq in reset", {7'd0, irq}, 8'h00);
      rst_n = 1'b1;

      // R1 reset values
      rreg(4'd0, "R1"); rreg(4'd1, "R1"); rreg(4'd2, "R1");
      rreg(4'd4, "R1"); rreg(4'd5, "R1"); rreg(4'd6, "R1"); rreg(4'd8, "R1");

      // R9 transfer-count writes
      wreg(4'd0, 8'h34, "R9"); wreg(4'd1, 8'h12, "R9"); wreg(4'd2, 8'h56, "R9");
      rreg(4'd0, "R9"); rreg(4'd1, "R9"); rreg(4'd2, "R9");

      // R6 DMA done
      pulse(5'b00010, "R6");
      rreg(4'd4, "R6"); rreg(4'd0, "R6"); rreg(4'd1, "R6"); rreg(4'd2, "R6"); rreg(4'd6, "R6");

      // R3 clear on read
      rreg(4'd5, "R3"); rreg(4'd4, "R3"); rreg(4'd6, "R3"); rreg(4'd5, "R3");

      // R9 count write clears terminal count
      pulse(5'b00010, "R9");
      wreg(4'd1, 8'h77, "R9"); rreg(4'd4, "R9"); rreg(4'd1, "R9"); rreg(4'd5, "R3");

      // R4 bus reset, reported and suppressed
      wreg(4'd3, 8'h03, "R4"); rreg(4'd4, "R4"); rreg(4'd5, "R4");
      wreg(4'd8, 8'h47, "R4"); wreg(4'd3, 8'h83, "R4");
      rreg(4'd4, "R4"); rreg(4'd5, "R4");
      pulse(5'b10000, "R4"); rreg(4'd4, "R4");
      pulse(5'b00100, "R4"); wreg(4'd3, 8'h03, "R4"); rreg(4'd4, "R4"); rreg(4'd5, "R4");
      wreg(4'd8, 8'h07, "R4"); pulse(5'b10000, "R4"); rreg(4'd4, "R4"); rreg(4'd5, "R3");

      // R5 selection timeout
      pulse(5'b00010, "R5"); pulse(5'b00001, "R5");
      rreg(4'd4, "R5"); rreg(4'd6, "R5"); rreg(4'd5, "R5");

      // R7 flush, line low then line high
      wreg(4'd3, 8'h01, "R7"); rreg(4'd6, "R7"); rreg(4'd4, "R7");
      pulse(5'b00100, "R7"); wreg(4'd3, 8'h81, "R7"); rreg(4'd6, "R7"); rreg(4'd5, "R7");

      // R8 message accept, disable selection
      wreg(4'd3, 8'h12, "R8"); rreg(4'd6, "R8"); rreg(4'd5, "R8");
      wreg(4'd3, 8'h45, "R8"); rreg(4'd4, "R8"); rreg(4'd5, "R8");

      // R11 read-only addresses
      pulse(5'b00010, "R11");
      wreg(4'd4, 8'h00, "R11"); wreg(4'd5, 8'hFF, "R11"); wreg(4'd6, 8'hFF, "R11");
      rreg(4'd4, "R11"); rreg(4'd6, "R11"); rreg(4'd5, "R11");

      // R13 function complete, bus service
      pulse(5'b00100, "R13"); rreg(4'd6, "R13"); rreg(4'd5, "R13");
      pulse(5'b01000, "R13"); rreg(4'd5, "R13");
      pulse(5'b00100, "R13"); pulse(5'b01000, "R13"); rreg(4'd4, "R13"); rreg(4'd5, "R13");

      // R10 event beats clear-on-read, priority among events
      pulse(5'b00010, "R10");
      step(1'b1, 1'b0, 4'd5, 8'h00, 5'b00100, "R10");
      rreg(4'd6, "R10"); rreg(4'd5, "R10");
      step(1'b0, 1'b1, 4'd0, 8'h99, 5'b00010, "R10");
      rreg(4'd0, "R10"); rreg(4'd4, "R10");
      pulse(5'b11111, "R10"); rreg(4'd4, "R10"); rreg(4'd5, "R10");
      pulse(5'b01110, "R10"); rreg(4'd4, "R10"); rreg(4'd5, "R10");
      pulse(5'b11000, "R10"); rreg(4'd5, "R10");

      // R12 soft reset, also against a coincident event
      wreg(4'd8, 8'h40, "R12"); wreg(4'd0, 8'h11, "R12"); pulse(5'b00001, "R12");
      wreg(4'd3, 8'h02, "R12");
      rreg(4'd0, "R12"); rreg(4'd1, "R12"); rreg(4'd2, "R12"); rreg(4'd4, "R12");
      rreg(4'd5, "R12"); rreg(4'd6, "R12"); rreg(4'd8, "R12");
      step(1'b0, 1'b1, 4'd3, 8'h82, 5'b00010, "R12");
      rreg(4'd4, "R12"); rreg(4'd2, "R12");

      // mixed pseudo-random traffic, model compared every cycle
      lfsr = 16'hACE1;
      for (int k = 0; k < 2000; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         case (lfsr[5:2])
            4'd0, 4'd9:   a = 4'd0;
            4'd1, 4'd10:  a = 4'd2;
            4'd2, 4'd11, 4'd12: a = 4'd3;
            4'd3, 4'd13:  a = 4'd4;
            4'd4, 4'd14, 4'd15: a = 4'd5;
            4'd5:         a = 4'd6;
            4'd6:         a = 4'd8;
            4'd7:         a = 4'd7;
            default:      a = 4'd1;
         endcase
         case (lfsr[8:6])
            3'd0: cmd = 8'h01;
            3'd1: cmd = 8'h03;
            3'd2: cmd = 8'h12;
            3'd3: cmd = 8'h45;
            3'd4: cmd = 8'h83;
            3'd5: cmd = 8'h00;
            3'd6: cmd = 8'h92;
            default: cmd = (lfsr[15:11] == 5'd0) ? 8'h02 : 8'h01;
         endcase
         wd = (a == 4'd3) ? cmd : (lfsr[15:8] ^ lfsr[7:0]);
         ev = (lfsr[15:13] == 3'd7) ? {lfsr[4], lfsr[9], lfsr[10], lfsr[11], lfsr[12]} : 5'b0;
         case (lfsr[1:0])
            2'd0:    step(1'b0, 1'b0, a, wd, ev, "R10 random");
            2'd2:    step(1'b0, 1'b1, a, wd, ev, "R11 random");
            default: step(1'b1, 1'b0, a, wd, ev, "R3 random");
         endcase
      end
      step(1'b0, 1'b0, 4'd0, 8'h00, 5'b0, "R2 idle");

      done = 1'b1;
      summary();
      $finish;
   end
endmodule